// File: doc/BRIEF.md
# Receive Buffer with Line Status

This block holds characters delivered by a serial receiver until software reads them. Each stored character carries its data byte and three per-character flags: bad parity, missing stop bit, and line break. The block works either as a single holding register or as a queue of `DEPTH` entries (64 by default). A mode input selects between them. A read strobe on the receive-data port removes the oldest character. The byte appears on the data output one cycle after the strobe.

An 8-bit line status word is formed continuously from the stored state. The flag bits describe the character at the head of the queue, not the most recently received one. A lost-data bit is sticky. A read strobe on the status port hands software the current word and clears the error bits that were just reported. A separate flush strobe empties the queue at once. The serial receiver, the transmitter and interrupt logic sit outside this block. The two transmitter bits of the status word read as constant 1.

Top module: `rxf_line_status`

## Requirements
- R1: With `fifo_en_i`=1, up to `DEPTH` characters are held. A character that arrives while `DEPTH` are held, with no pop in the same cycle, is discarded. It sets the lost-data bit, `lsr_o[1]`, from the next cycle.
- R2: With `fifo_en_i`=0, one character is held. A character that arrives while it is unread is discarded and sets `lsr_o[1]`. The held character is still returned by the next read.
- R3: `lsr_o[2]` (parity), `lsr_o[3]` (stop bit) and `lsr_o[4]` (break) show the flags of the oldest held character. They read 0 when nothing is held.
- R4: A status read strobe returns the word of that cycle. From the next cycle it clears `lsr_o[1]`, and it clears `lsr_o[4:2]` for the character then at the head. When a later character reaches the head, its own flags show again.
- R5: `lsr_o[0]` is 1 exactly when at least one character is held.
- R6: A data read strobe while data is held places the oldest byte on `rbr_data_o` in the next cycle. Characters leave in arrival order.
- R7: After reset, `lsr_o` is 0x60 (bits 5 and 6 set, all others clear), `rbr_data_o` is 0x00 and nothing is held.
- R8: A flush strobe empties the store in one cycle and clears `lsr_o[0]`. It leaves `lsr_o[1]` unchanged. A character arriving in the flush cycle is discarded without setting `lsr_o[1]`.
- R9: When a status read and a new error fall in the same cycle, the new error stays reported. This applies to a lost character, and to a flagged character arriving into an empty store.
- R10: A data read strobe while nothing is held leaves `rbr_data_o` unchanged and moves no pointer. A later character is read back correctly.
- R11: An arrival and a data read in the same cycle while the store is full are both accepted, and `lsr_o[1]` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en_i | input | 1 | 1 = queue of DEPTH entries, 0 = single holding register |
| rx_valid_i | input | 1 | A received character is presented this cycle |
| rx_data_i | input | 8 | Received data byte |
| rx_perr_i | input | 1 | Received character failed its parity check |
| rx_ferr_i | input | 1 | Received character had no valid stop bit |
| rx_brk_i | input | 1 | Received character was a line break |
| flush_i | input | 1 | Empty the store |
| rbr_rd_i | input | 1 | Data read strobe, pops the oldest character |
| lsr_rd_i | input | 1 | Status read strobe, clears reported errors |
| rbr_data_o | output | 8 | Last byte read out |
| lsr_o | output | 8 | Line status word |

## Verification
The hardest states to reach are the same-cycle collisions. One is a status-read clear meeting a fresh overrun. The other is a flagged character landing in an empty store in the very cycle the status word is read. Both need the store's fill level set up precisely first. The bench fills a small store to its exact capacity, then raises the arrival and status-read strobes in the same cycle. It then drains the store and repeats the collision with an arrival into the empty store. The full-store case is also crossed with a simultaneous pop, to separate an accepted arrival from a lost one.

// File: rtl/rxf_pkg.sv
// Shared types for the receive buffer.
// Assumes an 8-bit character; the flags travel with the byte.
package rxf_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    localparam int unsigned ENTRY_W = $bits(rx_entry_t);

endpackage

// File: rtl/rxf_store.sv
// Circular character store with pointer and fill-count control.
// Capacity is DEPTH in queue mode and 1 in single-register mode.
// Assumes the mode changes only while the store is empty.
// Reports accepted pops, head changes and lost arrivals to the status logic.
module rxf_store
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fifo_en_i,
    input  logic      push_req_i,
    input  rx_entry_t push_entry_i,
    input  logic      pop_req_i,
    input  logic      flush_i,
    output rx_entry_t head_o,
    output logic      empty_o,
    output logic      pop_o,
    output logic      head_chg_o,
    output logic      overrun_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [CW-1:0] count_q;
    logic [CW-1:0] cap;
    logic          full;
    logic          push_ok;

    // Capacity and accept decisions for this cycle.
    always_comb begin
        cap        = fifo_en_i ? CW'(DEPTH) : CW'(1);
        full       = (count_q >= cap);
        empty_o    = (count_q == '0);
        pop_o      = pop_req_i && !empty_o && !flush_i;
        push_ok    = push_req_i && !flush_i && (!full || pop_o);
        overrun_o  = push_req_i && !flush_i && full && !pop_o;
        head_chg_o = flush_i || pop_o || (push_ok && empty_o);
        head_o     = mem[rd_ptr_q];
    end

    // Storage array write; holds contents without reset.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr_q] <= push_entry_i;
        end
    end

    // Pointer and fill-count update with flush taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop_o) begin
                rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({push_ok, pop_o})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH)); // R1

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en_i && count_q == CW'(1) && push_req_i && !pop_req_i && !flush_i)
        |=> (count_q == CW'(1))); // R2

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o); // R8

    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req_i && pop_req_i && !flush_i) |=> (count_q == $past(count_q))); // R11

endmodule

// File: rtl/rxf_status.sv
// Line status word generator.
// Holds the sticky lost-data bit and an acknowledge flag for the head character.
// Assumes head_chg_i pulses whenever a different character becomes the head.
module rxf_status
    import rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rx_entry_t head_i,
    input  logic      empty_i,
    input  logic      head_chg_i,
    input  logic      overrun_i,
    input  logic      lsr_rd_i,
    output logic [7:0] lsr_o
);
    logic oe_q;
    logic ack_q;
    logic show;

    // Sticky lost-data bit: a new loss beats a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (overrun_i) begin
            oe_q <= 1'b1;
        end else if (lsr_rd_i) begin
            oe_q <= 1'b0;
        end
    end

    // Head acknowledge: set by a status read, dropped when the head changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else if (head_chg_i) begin
            ack_q <= 1'b0;
        end else if (lsr_rd_i) begin
            ack_q <= 1'b1;
        end
    end

    // Assemble the status word from stored state only.
    always_comb begin
        show  = !empty_i && !ack_q;
        lsr_o = {1'b0, 1'b1, 1'b1,
                 show && head_i.brk,
                 show && head_i.ferr,
                 show && head_i.perr,
                 oe_q,
                 !empty_i};
    end

    AST_OE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_i |=> lsr_o[1]); // R1

    AST_OE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd_i && !overrun_i) |=> !lsr_o[1]); // R4

    AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd_i && overrun_i) |=> lsr_o[1]); // R9

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        empty_i |-> (lsr_o[4:2] == 3'b000)); // R3

endmodule

// File: rtl/rxf_rdport.sv
// Read-data register: captures the head byte on an accepted pop.
// Keeps its value when a read finds nothing to pop.
module rxf_rdport
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pop_i,
    input  rx_entry_t  head_i,
    output logic [7:0] data_o
);
    // Latch the popped byte; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= 8'h00;
        end else if (pop_i) begin
            data_o <= head_i.data;
        end
    end

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_i |=> $stable(data_o)); // R10

endmodule

// File: rtl/rxf_line_status.sv
// Top: receive character store with line status word.
// Joins the store, the status generator and the read-data register.
// Assumes fifo_en_i is changed only while the store is empty.
module rxf_line_status
    import rxf_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    input  logic       rx_perr_i,
    input  logic       rx_ferr_i,
    input  logic       rx_brk_i,
    input  logic       flush_i,
    input  logic       rbr_rd_i,
    input  logic       lsr_rd_i,
    output logic [7:0] rbr_data_o,
    output logic [7:0] lsr_o
);
    rx_entry_t in_entry;
    rx_entry_t head;
    logic      empty;
    logic      pop;
    logic      head_chg;
    logic      overrun;

    // Pack the incoming character with its flags.
    always_comb begin
        in_entry.data = rx_data_i;
        in_entry.perr = rx_perr_i;
        in_entry.ferr = rx_ferr_i;
        in_entry.brk  = rx_brk_i;
    end

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en_i    (fifo_en_i),
        .push_req_i   (rx_valid_i),
        .push_entry_i (in_entry),
        .pop_req_i    (rbr_rd_i),
        .flush_i      (flush_i),
        .head_o       (head),
        .empty_o      (empty),
        .pop_o        (pop),
        .head_chg_o   (head_chg),
        .overrun_o    (overrun)
    );

    rxf_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_i     (head),
        .empty_i    (empty),
        .head_chg_i (head_chg),
        .overrun_i  (overrun),
        .lsr_rd_i   (lsr_rd_i),
        .lsr_o      (lsr_o)
    );

    rxf_rdport u_rdport (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop_i  (pop),
        .head_i (head),
        .data_o (rbr_data_o)
    );

    AST_DR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !flush_i) |=> lsr_o[0]); // R5

endmodule

// File: tb/rxf_line_status_bench.sv
// Sweeps a small store (DEPTH 8) through fill, drain, collisions and modes.
module rxf_line_status_bench;
    localparam int   DEPTH  = 8;
    localparam time  CLK_PD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_perr = 1'b0;
    logic       rx_ferr = 1'b0;
    logic       rx_brk = 1'b0;
    logic       flush = 1'b0;
    logic       rbr_rd = 1'b0;
    logic       lsr_rd = 1'b0;
    logic [7:0] rbr_data;
    logic [7:0] lsr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PD / 2) clk = ~clk;

    rxf_line_status #(.DEPTH(DEPTH)) u_rxf_line_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en_i  (fifo_en),
        .rx_valid_i (rx_valid),
        .rx_data_i  (rx_data),
        .rx_perr_i  (rx_perr),
        .rx_ferr_i  (rx_ferr),
        .rx_brk_i   (rx_brk),
        .flush_i    (flush),
        .rbr_rd_i   (rbr_rd),
        .lsr_rd_i   (lsr_rd),
        .rbr_data_o (rbr_data),
        .lsr_o      (lsr)
    );

    function automatic logic [7:0] dval(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // All drive tasks start and end at a falling edge.
    task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
        rx_valid = 1'b1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic pop();
        rbr_rd = 1'b1;
        @(negedge clk);
        rbr_rd = 1'b0;
    endtask

    task automatic rdlsr(output logic [7:0] v);
        v = lsr;
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
    endtask

    task automatic fill_plain();
        for (int i = 0; i < DEPTH; i++) push(dval(i), 1'b0, 1'b0, 1'b0);
    endtask

    task automatic drain();
        for (int i = 0; i < DEPTH + 1; i++) pop();
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: reset state
        chk("R7 lsr", lsr, 8'h60);
        chk("R7 rbr", rbr_data, 8'h00);

        // R1/R3/R5/R6: fill queue with patterned flags, overrun, drain
        fifo_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            push(dval(i), i[0], i[1], i == 3);
            if (i == 0) chk("R5 dr after first", {7'b0, lsr[0]}, 8'h01);
        end
        chk("R1 no loss at capacity", {7'b0, lsr[1]}, 8'h00);
        push(8'hEE, 1'b1, 1'b1, 1'b1);
        chk("R1 overrun set", {7'b0, lsr[1]}, 8'h01);
        for (int i = 0; i < DEPTH; i++) begin
            logic [2:0] fl;
            fl = {(i == 3) ? 1'b1 : 1'b0, i[1] ? 1'b1 : 1'b0, i[0] ? 1'b1 : 1'b0};
            chk("R3 head flags", {5'b0, lsr[4:2]}, {5'b0, fl});
            chk("R5 dr while held", {7'b0, lsr[0]}, 8'h01);
            pop();
            chk("R6 order", rbr_data, dval(i));
        end
        chk("R1 dropped byte absent", {7'b0, lsr[0]}, 8'h00);
        pop();
        chk("R10 empty read keeps data", rbr_data, dval(DEPTH - 1));
        rdlsr(v);
        chk("R4 read returns oe", {7'b0, v[1]}, 8'h01);
        rdlsr(v);
        chk("R4 oe cleared", {7'b0, v[1]}, 8'h00);
        push(8'h5A, 1'b0, 1'b0, 1'b0);
        pop();
        chk("R10 pointers intact", rbr_data, 8'h5A);

        // R4: acknowledge of head flags and fresh flags for next head
        push(8'h11, 1'b1, 1'b1, 1'b1);
        rdlsr(v);
        chk("R4 returned flags", {5'b0, v[4:2]}, 8'h07);
        chk("R4 flags cleared", {5'b0, lsr[4:2]}, 8'h00);
        chk("R5 dr kept", {7'b0, lsr[0]}, 8'h01);
        push(8'h22, 1'b0, 1'b1, 1'b0);
        chk("R3 head still acked", {5'b0, lsr[4:2]}, 8'h00);
        pop();
        chk("R4 next head fresh", {5'b0, lsr[4:2]}, 8'h02);
        pop();
        chk("R6 second byte", rbr_data, 8'h22);

        // R9: status read collides with an overrun
        fill_plain();
        rx_valid = 1'b1; rx_data = 8'h99; lsr_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; lsr_rd = 1'b0;
        chk("R9 overrun beats clear", {7'b0, lsr[1]}, 8'h01);
        drain();
        rdlsr(v);
        // R9: flagged arrival into empty store with status read
        rx_valid = 1'b1; rx_data = 8'h33; rx_perr = 1'b1; lsr_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; lsr_rd = 1'b0;
        chk("R9 new parity kept", {7'b0, lsr[2]}, 8'h01);
        pop();

        // R11: full queue, arrival and pop together
        fill_plain();
        rx_valid = 1'b1; rx_data = 8'hE8; rbr_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rbr_rd = 1'b0;
        chk("R11 no overrun", {7'b0, lsr[1]}, 8'h00);
        chk("R11 popped head", rbr_data, dval(0));
        for (int i = 1; i < DEPTH; i++) begin
            pop();
            chk("R11 order", rbr_data, dval(i));
        end
        pop();
        chk("R11 late arrival kept", rbr_data, 8'hE8);

        // R8: flush empties, keeps overrun; arrival in flush cycle dropped
        fill_plain();
        push(8'h44, 1'b0, 1'b0, 1'b0);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R8 dr cleared", {7'b0, lsr[0]}, 8'h00);
        chk("R8 oe kept", {7'b0, lsr[1]}, 8'h01);
        rdlsr(v);
        flush = 1'b1; rx_valid = 1'b1; rx_data = 8'h55;
        @(negedge clk);
        flush = 1'b0; rx_valid = 1'b0;
        chk("R8 flush-cycle byte dropped", lsr, 8'h60);
        push(8'h77, 1'b0, 1'b0, 1'b0);
        pop();
        chk("R8 after flush", rbr_data, 8'h77);

        // R2: single holding register mode
        fifo_en = 1'b0;
        push(8'hA1, 1'b0, 1'b1, 1'b0);
        chk("R3 held flags", {5'b0, lsr[4:2]}, 8'h02);
        push(8'hB2, 1'b0, 1'b0, 1'b0);
        chk("R2 overrun", {7'b0, lsr[1]}, 8'h01);
        pop();
        chk("R2 first kept", rbr_data, 8'hA1);
        chk("R2 empty after read", {7'b0, lsr[0]}, 8'h00);
        rdlsr(v);

        // R11: single register, arrival with read
        push(8'hC3, 1'b0, 1'b0, 1'b0);
        rx_valid = 1'b1; rx_data = 8'hD4; rbr_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rbr_rd = 1'b0;
        chk("R11 single read", rbr_data, 8'hC3);
        chk("R11 single no loss", lsr, 8'h61);
        pop();
        chk("R11 single next", rbr_data, 8'hD4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule